// File: doc/BRIEF.md
# Packet Queue Interrupt Controller

This block keeps track of packet numbers for the transmit and receive sides of a network controller, and it derives interrupts from the state of its queues. Software pushes allocated packet numbers into a transmit queue. A transmitter engine takes these numbers one at a time through a ready/take handshake. When a transmission finishes, the engine reports a pass or fatal result together with a status word. The block places finished packets in a completion FIFO. Software reads the head of that FIFO through a port, so it needs no list of its own of the packets in flight.

The receiver pushes numbers into a receive queue, and software drains it. Three interrupt sources exist: receive pending, transmit complete and transmit empty. Each source has an enable bit, and the enabled sources are ORed onto one IRQ output.

With the auto-release input set, successful completions skip the completion FIFO and go straight out on a release port to the buffer allocator. Fatal results are still queued. Combined with the transmit-empty event, this lets software pick one interrupt per packet or one per batch.

Top module: `pktq_irq_ctrl`

## Requirements
- R1: Status bit 0 (receive pending) is 1 in the cycle after any edge that leaves the receive queue non-empty, and it stays 1 until the queue is empty again.
- R2: Status bit 1 (transmit complete) is 1 exactly while the completion FIFO holds at least one entry.
- R3: Status bit 2 (transmit empty) is a latched event. It is set after a successful completion that finds the transmit queue empty with no push in that cycle. It is cleared by a pulse on ack bit 2. A set in the same cycle as the clear wins.
- R4: With auto_rel at 0, every completion enters the completion FIFO in completion order. Each entry holds the in-flight packet number and its status word.
- R5: With auto_rel at 1, a successful completion drives rel_vld high and rel_num with its packet number in the same cycle, and it adds nothing to the completion FIFO. rel_vld is low at all other times.
- R6: A fatal completion (done_ok at 0) is queued whatever auto_rel is. It sets halted, and it holds eng_rdy low until a restart pulse. It does not set transmit empty.
- R7: Both read ports return {empty, 1'b0, number}, so an empty queue reads 0x80. A pop of an empty queue is ignored.
- R8: irq is the OR of the status bits ANDed with int_en. Masking changes only irq and never the status bits.
- R9: A push to a full 32-entry queue is dropped and sets a sticky ovf bit: bit 0 for the transmit queue, bit 1 for the completion FIFO, bit 2 for the receive queue. A pulse on ack bit 3+i clears ovf bit i.
- R10: eng_rdy is high when the transmit queue is non-empty, the block is not halted and no packet is in flight. eng_num shows the head. A take pops numbers in push order. done_vld is ignored while nothing is in flight.
- R11: After reset, all queues are empty, and status, ovf, halted, eng_rdy, rel_vld and irq are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_push | input | 1 | Software pushes a packet number to the transmit queue |
| tx_push_num | input | 6 | Number pushed to the transmit queue |
| eng_rdy | output | 1 | A packet is available to the engine |
| eng_num | output | 6 | Head of the transmit queue |
| eng_take | input | 1 | Engine takes the head packet |
| done_vld | input | 1 | Engine reports completion of the in-flight packet |
| done_ok | input | 1 | 1 = success, 0 = fatal error |
| done_stat | input | 16 | Completion status word |
| rel_vld | output | 1 | Auto-release of a packet number |
| rel_num | output | 6 | Released packet number |
| cmp_pop | input | 1 | Pop the completion FIFO |
| cmp_head | output | 8 | Completion head: {empty, 0, number} |
| cmp_stat | output | 16 | Status word at the completion head |
| rx_push | input | 1 | Receiver pushes a packet number |
| rx_push_num | input | 6 | Received packet number |
| rx_pop | input | 1 | Pop the receive queue |
| rx_head | output | 8 | Receive head: {empty, 0, number} |
| auto_rel | input | 1 | Auto-release mode |
| restart | input | 1 | Leave the halted state |
| int_en | input | 3 | Interrupt enables, one per status bit |
| ack | input | 6 | Write-one clear: bit 2 transmit empty, bits 5:3 ovf |
| int_stat | output | 3 | Status: bit 0 receive, bit 1 transmit complete, bit 2 transmit empty |
| ovf | output | 3 | Sticky overflow flags |
| halted | output | 1 | Transmitter stopped after a fatal error |
| irq | output | 1 | Interrupt request |

## Verification
The transmit path runs in both modes. Two successes with auto_rel clear show that completions are queued in order and that transmit empty waits for the last packet. A single success with auto_rel set shows the bypass to the release port. A fatal result followed by a queued packet separates "queued despite auto-release" from "halted until restart". Receive traffic is run masked and unmasked to tell status from irq. Filling a queue past capacity and then draining it shows both the drop and the sticky flag.

// File: rtl/pktq_pkg.sv
package pktq_pkg;
    localparam int NSRC        = 3;
    localparam int IRQ_RX      = 0;
    localparam int IRQ_TXC     = 1;
    localparam int IRQ_TXE     = 2;
    localparam int ACK_OVF_LSB = 3;
    localparam int ACK_W       = ACK_OVF_LSB + NSRC;
    localparam int OVF_TXQ     = 0;
    localparam int OVF_CMP     = 1;
    localparam int OVF_RXQ     = 2;
endpackage

// File: rtl/pktq_fifo.sv
module pktq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         drop
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic [W-1:0] mem [DEPTH];
    logic full, do_push, do_pop;

    assign full    = (s_q.cnt == FULL_CNT);
    assign empty   = (s_q.cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign drop    = push && full;
    assign head    = mem[s_q.rp];

    always_comb begin
        s_d = s_q;
        if (do_push) s_d.wp = s_q.wp + 1'b1;
        if (do_pop)  s_d.rp = s_q.rp + 1'b1;
        s_d.cnt = s_q.cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[s_q.wp] <= push_data;
    end
endmodule

// File: rtl/pktq_irq_ctrl.sv
module pktq_irq_ctrl
    import pktq_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int NUM_W  = 6,
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_push,
    input  logic [NUM_W-1:0]  tx_push_num,
    output logic              eng_rdy,
    output logic [NUM_W-1:0]  eng_num,
    input  logic              eng_take,
    input  logic              done_vld,
    input  logic              done_ok,
    input  logic [STAT_W-1:0] done_stat,
    output logic              rel_vld,
    output logic [NUM_W-1:0]  rel_num,
    input  logic              cmp_pop,
    output logic [NUM_W+1:0]  cmp_head,
    output logic [STAT_W-1:0] cmp_stat,
    input  logic              rx_push,
    input  logic [NUM_W-1:0]  rx_push_num,
    input  logic              rx_pop,
    output logic [NUM_W+1:0]  rx_head,
    input  logic              auto_rel,
    input  logic              restart,
    input  logic [NSRC-1:0]   int_en,
    input  logic [ACK_W-1:0]  ack,
    output logic [NSRC-1:0]   int_stat,
    output logic [NSRC-1:0]   ovf,
    output logic              halted,
    output logic              irq
);
    localparam int CW = NUM_W + STAT_W;

    typedef struct packed {
        logic             busy;
        logic             halt;
        logic             txe;
        logic [NSRC-1:0]  ovf;
        logic [NUM_W-1:0] infl;
    } ctl_t;

    ctl_t c_d, c_q;

    logic             txq_empty, txq_drop, txq_pop;
    logic [NUM_W-1:0] txq_head;
    logic             cmp_empty, cmp_drop, cmp_push;
    logic [CW-1:0]    cmp_data;
    logic             rxq_empty, rxq_drop;
    logic [NUM_W-1:0] rxq_head;
    logic             done_fire, take_fire, bypass;

    pktq_fifo #(.W(NUM_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .push_data(tx_push_num),
        .pop(txq_pop), .head(txq_head), .empty(txq_empty), .drop(txq_drop)
    );

    pktq_fifo #(.W(CW), .DEPTH(DEPTH)) u_cmpq (
        .clk(clk), .rst_n(rst_n), .push(cmp_push), .push_data({c_q.infl, done_stat}),
        .pop(cmp_pop), .head(cmp_data), .empty(cmp_empty), .drop(cmp_drop)
    );

    pktq_fifo #(.W(NUM_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .push_data(rx_push_num),
        .pop(rx_pop), .head(rxq_head), .empty(rxq_empty), .drop(rxq_drop)
    );

    assign eng_rdy   = !txq_empty && !c_q.halt && !c_q.busy;
    assign eng_num   = txq_head;
    assign take_fire = eng_take && eng_rdy;
    assign txq_pop   = take_fire;
    assign done_fire = done_vld && c_q.busy;
    assign bypass    = done_fire && done_ok && auto_rel;
    assign cmp_push  = done_fire && !bypass;
    assign rel_vld   = bypass;
    assign rel_num   = c_q.infl;

    assign cmp_head = cmp_empty ? {1'b1, {(NUM_W+1){1'b0}}}
                                : {2'b00, cmp_data[CW-1:STAT_W]};
    assign cmp_stat = cmp_empty ? '0 : cmp_data[STAT_W-1:0];
    assign rx_head  = rxq_empty ? {1'b1, {(NUM_W+1){1'b0}}} : {2'b00, rxq_head};

    always_comb begin
        int_stat          = '0;
        int_stat[IRQ_RX]  = !rxq_empty;
        int_stat[IRQ_TXC] = !cmp_empty;
        int_stat[IRQ_TXE] = c_q.txe;
    end

    assign irq    = |(int_stat & int_en);
    assign ovf    = c_q.ovf;
    assign halted = c_q.halt;

    always_comb begin
        c_d = c_q;
        if (take_fire) begin
            c_d.busy = 1'b1;
            c_d.infl = txq_head;
        end
        if (done_fire) c_d.busy = 1'b0;
        if (done_fire && !done_ok) c_d.halt = 1'b1;
        else if (restart)          c_d.halt = 1'b0;
        c_d.txe = (c_q.txe && !ack[IRQ_TXE])
               || (done_fire && done_ok && txq_empty && !tx_push);
        c_d.ovf = c_q.ovf & ~ack[ACK_OVF_LSB +: NSRC];
        c_d.ovf[OVF_TXQ] = c_d.ovf[OVF_TXQ] | txq_drop;
        c_d.ovf[OVF_CMP] = c_d.ovf[OVF_CMP] | cmp_drop;
        c_d.ovf[OVF_RXQ] = c_d.ovf[OVF_RXQ] | rxq_drop;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end
endmodule

// File: rtl/pktq_irq_ctrl_chk.sv
module pktq_irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       done_vld,
    input logic       done_ok,
    input logic       auto_rel,
    input logic       rel_vld,
    input logic       halted,
    input logic       eng_rdy,
    input logic [2:0] int_en,
    input logic [2:0] int_stat,
    input logic       irq,
    input logic [7:0] cmp_head
);
    a_r5_release_source: assert property (@(posedge clk) disable iff (!rst_n)
        rel_vld |-> (auto_rel && done_vld && done_ok));

    a_r6_halt_blocks_engine: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !eng_rdy);

    a_r6_halt_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> $past(done_vld && !done_ok));

    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en == 3'b000) |-> !irq);

    a_r7_empty_code: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_head[7] |-> (cmp_head[6:0] == 7'd0));

    a_r3_txe_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_stat[2]) |-> $past(done_vld && done_ok));
endmodule

bind pktq_irq_ctrl pktq_irq_ctrl_chk u_chk (.*);

// File: tb/pktq_irq_ctrl_tb.sv
module pktq_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_push = 0, eng_take = 0, done_vld = 0, done_ok = 0;
    logic [5:0]  tx_push_num = 0, rx_push_num = 0;
    logic [15:0] done_stat = 0;
    logic        cmp_pop = 0, rx_push = 0, rx_pop = 0, auto_rel = 0, restart = 0;
    logic [2:0]  int_en = 0;
    logic [5:0]  ack = 0;
    logic        eng_rdy, rel_vld, halted, irq;
    logic [5:0]  eng_num, rel_num;
    logic [7:0]  cmp_head, rx_head;
    logic [15:0] cmp_stat;
    logic [2:0]  int_stat, ovf;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pktq_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .tx_push(tx_push), .tx_push_num(tx_push_num),
        .eng_rdy(eng_rdy), .eng_num(eng_num), .eng_take(eng_take),
        .done_vld(done_vld), .done_ok(done_ok), .done_stat(done_stat),
        .rel_vld(rel_vld), .rel_num(rel_num), .cmp_pop(cmp_pop),
        .cmp_head(cmp_head), .cmp_stat(cmp_stat), .rx_push(rx_push),
        .rx_push_num(rx_push_num), .rx_pop(rx_pop), .rx_head(rx_head),
        .auto_rel(auto_rel), .restart(restart), .int_en(int_en), .ack(ack),
        .int_stat(int_stat), .ovf(ovf), .halted(halted), .irq(irq)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic push_tx(logic [5:0] n);
        tx_push = 1; tx_push_num = n; step(); tx_push = 0;
    endtask

    task automatic push_rx(logic [5:0] n);
        rx_push = 1; rx_push_num = n; step(); rx_push = 0;
    endtask

    task automatic take();
        eng_take = 1; step(); eng_take = 0;
    endtask

    task automatic pulse_ack(logic [5:0] a);
        ack = a; step(); ack = 0;
    endtask

    task automatic t_reset();
        check("R11 int_stat", int_stat, 0);
        check("R11 ovf", ovf, 0);
        check("R11 halted", halted, 0);
        check("R11 eng_rdy", eng_rdy, 0);
        check("R11 rel_vld", rel_vld, 0);
        check("R11 irq", irq, 0);
        check("R7 cmp empty code", cmp_head, 8'h80);
        check("R7 rx empty code", rx_head, 8'h80);
    endtask

    task automatic t_rx();
        push_rx(6'd10); push_rx(6'd11); push_rx(6'd12);
        check("R1 rx pending", int_stat[0], 1);
        int_en = 3'b001; #1;
        check("R8 irq enabled", irq, 1);
        int_en = 3'b000; #1;
        check("R8 irq masked", irq, 0);
        check("R8 status kept while masked", int_stat[0], 1);
        for (int i = 0; i < 3; i++) begin
            check("R1 rx order", rx_head, 8'(10 + i));
            check("R1 rx still pending", int_stat[0], 1);
            rx_pop = 1; step(); rx_pop = 0;
        end
        check("R1 rx drained", int_stat[0], 0);
        rx_pop = 1; step(); rx_pop = 0;
        check("R7 empty pop ignored", rx_head, 8'h80);
    endtask

    task automatic t_per_packet();
        auto_rel = 0;
        done_vld = 1; done_ok = 1; step(); done_vld = 0;
        check("R10 done ignored when idle", int_stat, 0);
        push_tx(6'd1); push_tx(6'd2);
        check("R10 rdy", eng_rdy, 1);
        check("R10 head", eng_num, 1);
        take();
        check("R10 busy blocks rdy", eng_rdy, 0);
        done_vld = 1; done_ok = 1; done_stat = 16'hA001; #1;
        check("R5 no release when off", rel_vld, 0);
        step(); done_vld = 0;
        check("R3 not empty yet", int_stat[2], 0);
        check("R10 second head", eng_num, 2);
        take();
        done_vld = 1; done_ok = 1; done_stat = 16'hA002; step(); done_vld = 0;
        check("R3 tx empty set", int_stat[2], 1);
        check("R2 tx complete", int_stat[1], 1);
        check("R4 first num", cmp_head, 8'd1);
        check("R4 first stat", cmp_stat, 16'hA001);
        cmp_pop = 1; step(); cmp_pop = 0;
        check("R4 second num", cmp_head, 8'd2);
        check("R4 second stat", cmp_stat, 16'hA002);
        cmp_pop = 1; step(); cmp_pop = 0;
        check("R2 complete cleared", int_stat[1], 0);
        check("R3 latched", int_stat[2], 1);
        pulse_ack(6'b000100);
        check("R3 ack clears", int_stat[2], 0);
    endtask

    task automatic t_auto();
        auto_rel = 1;
        push_tx(6'd7); take();
        done_vld = 1; done_ok = 1; done_stat = 16'h0077; #1;
        check("R5 rel_vld", rel_vld, 1);
        check("R5 rel_num", rel_num, 7);
        step(); done_vld = 0;
        check("R5 fifo bypassed", cmp_head, 8'h80);
        check("R2 no complete", int_stat[1], 0);
        check("R3 empty event", int_stat[2], 1);
        int_en = 3'b100; #1;
        check("R8 irq on txe", irq, 1);
        int_en = 0;
        pulse_ack(6'b000100);
    endtask

    task automatic t_fatal();
        auto_rel = 1;
        push_tx(6'd3); push_tx(6'd4); take();
        done_vld = 1; done_ok = 0; done_stat = 16'hE000; #1;
        check("R6 fatal not released", rel_vld, 0);
        step(); done_vld = 0;
        check("R6 halted", halted, 1);
        check("R6 rdy blocked", eng_rdy, 0);
        check("R6 queued num", cmp_head, 8'd3);
        check("R6 queued stat", cmp_stat, 16'hE000);
        check("R6 complete raised", int_stat[1], 1);
        check("R6 no tx empty", int_stat[2], 0);
        step();
        check("R6 still halted", eng_rdy, 0);
        restart = 1; step(); restart = 0;
        check("R6 restart", eng_rdy, 1);
        check("R6 next head", eng_num, 4);
        take();
        done_vld = 1; done_ok = 1; #1;
        check("R5 release after restart", rel_num, 4);
        step(); done_vld = 0;
        cmp_pop = 1; step(); cmp_pop = 0;
        check("R7 completion drained", cmp_head, 8'h80);
        pulse_ack(6'b000100);
        auto_rel = 0;
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 33; i++) push_rx(6'(i));
        check("R9 rx overflow", ovf, 3'b100);
        pulse_ack(6'b100000);
        check("R9 ack clears", ovf, 0);
        for (int i = 0; i < 32; i++) begin
            check("R9 kept entry", rx_head, 8'(i));
            rx_pop = 1; step(); rx_pop = 0;
        end
        check("R9 extra dropped", rx_head, 8'h80);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        step();
        t_reset();
        t_rx();
        t_per_packet();
        t_auto();
        t_fatal();
        t_overflow();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule